// File: doc/BRIEF.md
# DMA Request Gate with Post-Write Blanking

This block sits in front of one DMA channel's transfer engine and decides when that engine sees a peripheral request. A two-bit select field picks one of four request lines. In handshake mode the chosen line goes through unchanged, with one register stage of delay. In no-handshake mode, every completed peripheral-width write starts a down-counter. While that counter runs, the request is blanked, which gives the peripheral time to drop its request line. The event that starts the counter depends on the source. For the external source it is the memory controller's write acknowledge. For the three internal sources it is the bus's write-accepted indication.

Software programs the block through a small register interface: a control register and a wait-count register. Any write to the control register clears a running blanking counter at once. The block also raises a next-buffer interrupt while the channel's buffer state (an input) is "buffer on", but only if the interrupt is enabled. Software can clear that enable when the current buffer is the last one.

Top module: `dma_req_gate`

## Requirements
- R1: Register 0 is the control register: bit 0 is the next-buffer interrupt enable, bits 2:1 are the source select, and bit 3 is the no-handshake mode. Register 1 holds the 8-bit wait count. `regRdData` returns the register that `regAddr` points at, combinationally; addresses 2 and 3 read as zero.
- R2: Source select 00 picks `reqExt`, 01 picks `reqSerRx`, 10 picks `reqSerTx` and 11 picks `reqDisk`. In handshake mode (bit 3 = 0), `reqOut` equals the selected request one clock later, and the blanking counter is never loaded.
- R3: In no-handshake mode, a write event with wait count N > 0 forces `reqOut` low from the edge that samples the event. `reqOut` stays low for exactly N clocks and then follows the selected request again.
- R4: With source 00 only `memWrAck` starts the counter. With sources 01–11 only `wrAccepted` starts it. The other event input has no effect.
- R5: A wait count of zero produces no blanking cycles.
- R6: A write to the control register clears a running counter on that edge and drives `reqOut` low on that edge. From the next edge, `reqOut` follows the newly selected source.
- R7: A new write event while the counter runs reloads it with the full wait count.
- R8: `nextBufIrq` is high exactly when the interrupt enable is 1 and `bufOn` is 1.
- R9: During reset, `reqOut`, `stallActive` and all register fields are zero.
- R10: `stallActive` is high exactly while the blanking counter is non-zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqExt | input | 1 | External request line (source 00) |
| reqSerRx | input | 1 | Internal serial receive request (source 01) |
| reqSerTx | input | 1 | Internal serial transmit request (source 10) |
| reqDisk | input | 1 | Internal disk interface request (source 11) |
| wrAccepted | input | 1 | Bus reports the write accepted and done (internal sources) |
| memWrAck | input | 1 | Memory controller write acknowledge (external source) |
| bufOn | input | 1 | Channel buffer state is buffer-on |
| regWr | input | 1 | Register write strobe |
| regAddr | input | 2 | Register address |
| regWrData | input | 8 | Register write data |
| regRdData | output | 8 | Register read data |
| reqOut | output | 1 | Gated request to the transfer engine, registered |
| stallActive | output | 1 | Blanking counter running |
| nextBufIrq | output | 1 | Next-buffer interrupt |

## Verification
The bound checker watches several rules on every cycle: blanking always keeps the request low, handshake mode never stalls and passes the request through with one cycle of delay, a control write always clears the stall, a load with a non-zero count always blanks on the next cycle, and a disabled interrupt never fires. Some behaviours only the bench scenarios can show. These are the exact length of the blanking window, reload during a running stall, the choice of trigger event for each source, the zero-count case, and register readback. The bench shows them by comparing against a behavioural model on every clock.

// File: rtl/dma_gate_pkg.sv
package dma_gate_pkg;

  typedef enum logic [1:0] {
    SRC_EXT    = 2'b00,
    SRC_SER_RX = 2'b01,
    SRC_SER_TX = 2'b10,
    SRC_DISK   = 2'b11
  } src_e;

  // control register layout, MSB first: noHs at bit 3, src at 2:1, intEn at 0
  typedef struct packed {
    logic noHs;
    src_e src;
    logic intEn;
  } cfg_t;

  localparam int CFG_W = $bits(cfg_t);

  // strobes from control to datapath
  typedef struct packed {
    logic cancel;
    logic load;
  } strobe_t;

endpackage

// File: rtl/dma_gate_ctrl.sv
module dma_gate_ctrl
  import dma_gate_pkg::*;
#(
  parameter int CNT_W  = 8,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWr,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [CNT_W-1:0]  regWrData,
  input  logic              wrAccepted,
  input  logic              memWrAck,
  input  logic              bufOn,
  output cfg_t              cfg,
  output logic [CNT_W-1:0]  waitCfg,
  output strobe_t           stb,
  output logic              nextBufIrq,
  output logic [CNT_W-1:0]  regRdData
);

  localparam logic [ADDR_W-1:0] ADDR_CTRL = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] ADDR_WAIT = ADDR_W'(1);

  logic ctrlWrite;
  logic waitWrite;
  logic trigEvt;

  assign ctrlWrite = regWr && (regAddr == ADDR_CTRL);
  assign waitWrite = regWr && (regAddr == ADDR_WAIT);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfg     <= '0;
      waitCfg <= '0;
    end else begin
      if (ctrlWrite) cfg <= cfg_t'(regWrData[CFG_W-1:0]);
      if (waitWrite) waitCfg <= regWrData;
    end
  end

  // trigger source depends on the selected request source
  assign trigEvt = (cfg.src == SRC_EXT) ? memWrAck : wrAccepted;

  always_comb begin
    stb.cancel = ctrlWrite;
    stb.load   = cfg.noHs && trigEvt && !ctrlWrite;
  end

  assign nextBufIrq = cfg.intEn && bufOn;

  always_comb begin
    regRdData = '0;
    if (regAddr == ADDR_CTRL) regRdData = CNT_W'(cfg);
    else if (regAddr == ADDR_WAIT) regRdData = waitCfg;
  end

endmodule

// File: rtl/dma_gate_path.sv
module dma_gate_path
  import dma_gate_pkg::*;
#(
  parameter int CNT_W   = 8,
  parameter int N_SRC   = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [N_SRC-1:0] reqVec,
  input  src_e             srcSel,
  input  logic [CNT_W-1:0] waitCfg,
  input  strobe_t          stb,
  output logic             reqOut,
  output logic             stallActive
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cntQ;
  logic [CNT_W-1:0] cntD;
  logic             selReq;
  logic             reqD;
  logic [N_SRC-1:0] srcHot;

  // one-hot source decode
  for (genvar gi = 0; gi < N_SRC; gi++) begin : g_src
    assign srcHot[gi] = (srcSel == src_e'(gi)) && reqVec[gi];
  end

  assign selReq = |srcHot;

  always_comb begin
    cntD = cntQ;
    if (stb.cancel)       cntD = '0;
    else if (stb.load)    cntD = waitCfg;
    else if (cntQ != '0)  cntD = cntQ - ONE;
  end

  assign reqD = !stb.cancel && selReq && (cntD == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntQ   <= '0;
      reqOut <= 1'b0;
    end else begin
      cntQ   <= cntD;
      reqOut <= reqD;
    end
  end

  assign stallActive = (cntQ != '0);

endmodule

// File: rtl/dma_req_gate.sv
module dma_req_gate
  import dma_gate_pkg::*;
#(
  parameter int CNT_W  = 8,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqExt,
  input  logic              reqSerRx,
  input  logic              reqSerTx,
  input  logic              reqDisk,
  input  logic              wrAccepted,
  input  logic              memWrAck,
  input  logic              bufOn,
  input  logic              regWr,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [CNT_W-1:0]  regWrData,
  output logic [CNT_W-1:0]  regRdData,
  output logic              reqOut,
  output logic              stallActive,
  output logic              nextBufIrq
);

  localparam int N_SRC = 4;

  cfg_t             cfg;
  logic [CNT_W-1:0] waitCfg;
  strobe_t          stb;
  logic [N_SRC-1:0] reqVec;

  assign reqVec = {reqDisk, reqSerTx, reqSerRx, reqExt};

  dma_gate_ctrl #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .regWr      (regWr),
    .regAddr    (regAddr),
    .regWrData  (regWrData),
    .wrAccepted (wrAccepted),
    .memWrAck   (memWrAck),
    .bufOn      (bufOn),
    .cfg        (cfg),
    .waitCfg    (waitCfg),
    .stb        (stb),
    .nextBufIrq (nextBufIrq),
    .regRdData  (regRdData)
  );

  dma_gate_path #(.CNT_W(CNT_W), .N_SRC(N_SRC)) uPath (
    .clk         (clk),
    .rstN        (rstN),
    .reqVec      (reqVec),
    .srcSel      (cfg.src),
    .waitCfg     (waitCfg),
    .stb         (stb),
    .reqOut      (reqOut),
    .stallActive (stallActive)
  );

endmodule

// File: rtl/dma_gate_checker.sv
module dma_gate_checker
  import dma_gate_pkg::*;
#(
  parameter int CNT_W  = 8,
  parameter int ADDR_W = 2
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqExt,
  input logic              reqSerRx,
  input logic              reqSerTx,
  input logic              reqDisk,
  input logic              regWr,
  input logic [ADDR_W-1:0] regAddr,
  input cfg_t              cfg,
  input logic [CNT_W-1:0]  waitCfg,
  input strobe_t           stb,
  input logic              reqOut,
  input logic              stallActive,
  input logic              nextBufIrq
);

  logic ctrlWr;
  logic pickedReq;

  assign ctrlWr = regWr && (regAddr == ADDR_W'(0));

  always_comb begin
    case (cfg.src)
      SRC_EXT:    pickedReq = reqExt;
      SRC_SER_RX: pickedReq = reqSerRx;
      SRC_SER_TX: pickedReq = reqSerTx;
      default:    pickedReq = reqDisk;
    endcase
  end

  AST_STALL_BLANKS: assert property (@(posedge clk) disable iff (!rstN)
    stallActive |-> !reqOut); // R3

  AST_LOAD_MASKS: assert property (@(posedge clk) disable iff (!rstN)
    (stb.load && waitCfg != '0) |=> (stallActive && !reqOut)); // R3

  AST_CANCEL_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    ctrlWr |=> (!stallActive && !reqOut)); // R6

  AST_HS_NO_STALL: assert property (@(posedge clk) disable iff (!rstN)
    !cfg.noHs |-> !stallActive); // R2

  AST_HS_PASS: assert property (@(posedge clk) disable iff (!rstN)
    (!cfg.noHs && !ctrlWr) |=> (reqOut == $past(pickedReq))); // R2

  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rstN)
    !cfg.intEn |-> !nextBufIrq); // R8

endmodule

bind dma_req_gate dma_gate_checker #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) uChk (
  .clk         (clk),
  .rstN        (rstN),
  .reqExt      (reqExt),
  .reqSerRx    (reqSerRx),
  .reqSerTx    (reqSerTx),
  .reqDisk     (reqDisk),
  .regWr       (regWr),
  .regAddr     (regAddr),
  .cfg         (cfg),
  .waitCfg     (waitCfg),
  .stb         (stb),
  .reqOut      (reqOut),
  .stallActive (stallActive),
  .nextBufIrq  (nextBufIrq)
);

// File: tb/sim_dma_req_gate.sv
`timescale 1ns/1ps
module sim_dma_req_gate;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       reqExt = 0, reqSerRx = 0, reqSerTx = 0, reqDisk = 0;
  logic       wrAccepted = 0, memWrAck = 0, bufOn = 0;
  logic       regWr = 0;
  logic [1:0] regAddr = 0;
  logic [7:0] regWrData = 0;
  logic [7:0] regRdData;
  logic       reqOut, stallActive, nextBufIrq;

  int    nTests = 0;
  int    nFails = 0;
  string curTag = "R9";

  // behavioural model state
  int mCnt = 0, mWait = 0, mSrc = 0;
  bit mNoHs = 0, mIntEn = 0, mReq = 0;

  always #10 clk = ~clk;

  dma_req_gate u0 (
    .clk(clk), .rstN(rstN), .reqExt(reqExt), .reqSerRx(reqSerRx),
    .reqSerTx(reqSerTx), .reqDisk(reqDisk), .wrAccepted(wrAccepted),
    .memWrAck(memWrAck), .bufOn(bufOn), .regWr(regWr), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .reqOut(reqOut),
    .stallActive(stallActive), .nextBufIrq(nextBufIrq)
  );

  task automatic check(input string what, input int act, input int exp);
    nTests++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", curTag, what, act, exp, $time);
    end
  endtask

  function automatic int expRd();
    if (regAddr == 0) return (int'(mNoHs) << 3) | (mSrc << 1) | int'(mIntEn);
    if (regAddr == 1) return mWait;
    return 0;
  endfunction

  always @(posedge clk) begin
    bit [3:0] rq;
    bit trig, sel;
    rq = {reqDisk, reqSerTx, reqSerRx, reqExt};
    if (!rstN) begin
      mCnt = 0; mWait = 0; mSrc = 0; mNoHs = 0; mIntEn = 0; mReq = 0;
    end else begin
      trig = mNoHs && ((mSrc == 0) ? memWrAck : wrAccepted);
      sel  = rq[mSrc];
      if (regWr && regAddr == 0) begin
        mCnt = 0; mReq = 0;
      end else begin
        if (trig) mCnt = mWait;
        else if (mCnt > 0) mCnt = mCnt - 1;
        mReq = sel && (mCnt == 0);
      end
      if (regWr && regAddr == 0) begin
        mNoHs = regWrData[3]; mSrc = int'(regWrData[2:1]); mIntEn = regWrData[0];
      end
      if (regWr && regAddr == 1) mWait = int'(regWrData);
    end
    #5;
    check("reqOut", int'(reqOut), int'(mReq));
    check("stallActive", int'(stallActive), int'(mCnt != 0));
    check("nextBufIrq", int'(nextBufIrq), int'(mIntEn && bufOn));
    check("regRdData", int'(regRdData), expRd());
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wrReg(input int a, input int d);
    @(negedge clk);
    regWr = 1; regAddr = 2'(a); regWrData = 8'(d);
    @(negedge clk);
    regWr = 0; regAddr = 0;
  endtask

  task automatic pulseMem();
    @(negedge clk); memWrAck = 1;
    @(negedge clk); memWrAck = 0;
  endtask

  task automatic pulseAcc();
    @(negedge clk); wrAccepted = 1;
    @(negedge clk); wrAccepted = 0;
  endtask

  initial begin
    #(200000 * 20);
    nFails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", nTests, nFails);
    $finish;
  end

  initial begin
    curTag = "R9";
    reqExt = 1; reqDisk = 1;
    cyc(4);
    rstN = 1;
    reqExt = 0; reqDisk = 0;
    cyc(2);

    curTag = "R1";
    wrReg(0, 8'h0D);
    wrReg(1, 8'hA5);
    @(negedge clk); regAddr = 0;
    @(negedge clk); regAddr = 1;
    @(negedge clk); regAddr = 2;
    @(negedge clk); regAddr = 3;
    @(negedge clk); regAddr = 0;

    curTag = "R2";
    wrReg(1, 4);
    for (int s = 0; s < 4; s++) begin
      wrReg(0, s << 1);
      for (int k = 0; k < 6; k++) begin
        @(negedge clk);
        {reqDisk, reqSerTx, reqSerRx, reqExt} = 4'(k * 5 + s);
        wrAccepted = k[0]; memWrAck = ~k[0];
      end
      @(negedge clk); wrAccepted = 0; memWrAck = 0;
    end
    {reqDisk, reqSerTx, reqSerRx, reqExt} = 4'b0;

    curTag = "R3";
    wrReg(1, 3);
    wrReg(0, 8'h08);
    reqExt = 1;
    cyc(2);
    pulseMem();
    cyc(6);

    curTag = "R4";
    pulseAcc();
    cyc(3);
    wrReg(0, 8'h0A);
    reqSerRx = 1;
    cyc(2);
    pulseMem();
    cyc(2);
    pulseAcc();
    cyc(6);

    curTag = "R5";
    wrReg(1, 0);
    pulseAcc();
    cyc(3);

    curTag = "R10";
    wrReg(1, 1);
    pulseAcc();
    cyc(3);

    curTag = "R6";
    wrReg(1, 10);
    pulseAcc();
    cyc(3);
    reqSerTx = 1;
    wrReg(0, 8'h0C);
    cyc(4);

    curTag = "R7";
    wrReg(1, 5);
    pulseAcc();
    cyc(2);
    pulseAcc();
    cyc(9);

    curTag = "R8";
    wrReg(0, 8'h01);
    bufOn = 1; cyc(2);
    bufOn = 0; cyc(2);
    bufOn = 1; cyc(1);
    wrReg(0, 8'h00);
    cyc(2);
    bufOn = 0;

    curTag = "R9";
    @(negedge clk); rstN = 0; reqExt = 1;
    cyc(3);
    rstN = 1;
    cyc(3);

    $display("[TB] %0d tests run, %0d failed", nTests, nFails);
    $finish;
  end

endmodule